// File: doc/BRIEF.md
# Audio Front-End Control Sequencer

This block sits between a settings interface and two write engines. One engine drives the board's external control latches: the system latch, the monitor latch and the clock/routing latch. The other sends register writes to the converter chips over a serial link. A request names one setting: master mute, phantom power, the mode of analog inputs 1/2, or a sample-rate hint for the converters. The block turns it into a short, fixed-order list of write commands, and issues them one at a time, waiting for each acknowledge.

The block holds the last value written to the system latch. It also holds the two converter registers it touches on every chip, so each converter write is a read-modify-write on that copy. A request whose result equals the stored state issues nothing. Out of reset, the block runs an initialization series before it takes requests. The latch strobing and the serial bit timing belong to the engines, not to this block.

Top module: `afe_ctrl_seq`

## Requirements
- R1: After reset the block issues exactly four latch writes, in this order: system 0x08, then system 0x88, then monitor (lat_sel=1) 0x00, then clock/routing (lat_sel=2) 0x00. req_ready stays low until the fourth one is acknowledged.
- R2: The system latch (lat_sel=0) bit layout is:
  - bit0: relay, 1 = mic.
  - bit1: phantom voltage, 1 = 48 V.
  - bit2: hardware mute.
  - bit3: phantom disable.
  - bits5:4: input-1/2 source.
  - bit7: converter run, 0 = power-down.
- R3: A phantom-on request (req_kind=1, arg[0]=1) acts only when bit1 is clear. It then writes the system latch twice: first with bit1 set, then additionally with bit3 cleared.
- R4: A phantom-off request (arg[0]=0) acts only when bit1 is set. It then writes twice: first with bit1 cleared, then additionally with bit3 set.
- R5: An input-mode request (req_kind=2) selects a source code: index 1 gives code 01 (mic), and index 2 gives code 11 (mic with low-cut). For either, the block first writes with the relay bit set, then writes with bits5:4 set to the code. Code 10 never appears.
- R6: Input-mode index 0 (line, code 00) first writes with bits5:4 cleared, then writes with the relay bit also cleared.
- R7: Input-mode index 3 issues no write.
- R8: A mute request (req_kind=0, arg[0]=1 mute, 0 unmute) that changes bit2 writes the system latch with the new bit2. It then writes converter register 3 (cdc_addr=3) on each chip in ascending order, with bit7 set to the mute value and the other bits kept from the stored copy.
- R9: A rate request (req_kind=3, arg = rate) writes converter register 2 (cdc_addr=2) bits3:0 on each chip, in ascending chip order, with the other bits kept:
  - 0xA (bit1 and bit3) when the rate is above 108000.
  - 0x5 (bit0 and bit2) when the rate is above 54000.
  - 0x0 otherwise.
- R10: A rate of 0, or any request whose result equals the stored state, issues no write. A chip whose converter register would not change is skipped.
- R11: Each command holds its valid and payload until acknowledged. Latch and converter commands never overlap. busy is high from acceptance until the last acknowledge, and a request is taken only while req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_kind | input | 2 | 0 mute, 1 phantom, 2 input mode, 3 rate hint |
| req_arg | input | ARG_W | Setting value or rate in Hz |
| req_ready | output | 1 | Idle and able to take a request |
| busy | output | 1 | Initialization or a request in progress |
| lat_valid | output | 1 | Latch write command valid |
| lat_sel | output | 2 | Latch select: 0 system, 1 monitor, 2 clock/routing |
| lat_data | output | 8 | Latch data |
| lat_ack | input | 1 | Latch write done |
| cdc_valid | output | 1 | Converter write command valid |
| cdc_chip | output | CHIP_W | Converter chip index |
| cdc_addr | output | 5 | Converter register address (2 or 3) |
| cdc_data | output | 8 | Converter register data |
| cdc_ack | input | 1 | Converter write done |

## Verification
Some properties are checked on every cycle by assertions:
- A command holds steady until it is acknowledged.
- The two engines are never addressed at once.
- The stored system value never holds source code 10.
- A nonzero source code is never present without the relay set.
- Phantom disable is cleared only while 48 V is selected, and set only after it is deselected.

The exact write lists can only be shown by the bench scenarios. These cover the initialization series, the data values, the per-chip converter order, the rate thresholds at 54000 and 108000 and just above them, and the absence of any write for no-op requests.

// File: rtl/afe_seq_pkg.sv
package afe_seq_pkg;

  typedef enum logic [1:0] {
    REQ_MUTE    = 2'd0,
    REQ_PHANTOM = 2'd1,
    REQ_INMODE  = 2'd2,
    REQ_RATE    = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    LAT_SYS = 2'd0,
    LAT_MON = 2'd1,
    LAT_CLK = 2'd2
  } lat_sel_e;

  // system latch bit positions, decoded by the board
  localparam int SYS_RELAY  = 0;
  localparam int SYS_PH48   = 1;
  localparam int SYS_MUTE   = 2;
  localparam int SYS_PHOFF  = 3;
  localparam int SYS_SRC_LO = 4;
  localparam int SYS_SRC_HI = 5;
  localparam int SYS_RUN    = 7;

  localparam logic [7:0] INIT_SYS_HOLD = 8'h08;
  localparam logic [7:0] INIT_SYS_RUN  = 8'h88;

  // converter register addresses and fields
  localparam logic [4:0] CDC_REG_FMT  = 5'd2;
  localparam logic [4:0] CDC_REG_VOL  = 5'd3;
  localparam logic [7:0] CDC_SMUTE    = 8'h80;
  localparam logic [7:0] CDC_FMT_MASK = 8'h0F;
  localparam logic [7:0] CDC_FMT_QUAD = 8'h0A;
  localparam logic [7:0] CDC_FMT_DUAL = 8'h05;

  typedef struct packed {
    logic       sys_a_en;
    logic [7:0] sys_a;
    logic       sys_b_en;
    logic [7:0] sys_b;
    logic       cdc_en;
    logic       cdc_vol;
    logic [7:0] cdc_mask;
    logic [7:0] cdc_val;
  } job_t;

endpackage

// File: rtl/afe_req_decode.sv
module afe_req_decode
  import afe_seq_pkg::*;
#(
  parameter int ARG_W    = 18,
  parameter int HI_RATE  = 108000,
  parameter int MID_RATE = 54000
) (
  input  logic [1:0]       req_kind,
  input  logic [ARG_W-1:0] req_arg,
  input  logic [7:0]       sys_cur,
  output job_t             job
);

  logic [1:0] src_code;
  logic       src_ok;
  logic [7:0] step_a;

  always_comb begin
    job      = '0;
    step_a   = sys_cur;
    src_ok   = (req_arg[1:0] != 2'd3);
    src_code = (req_arg[1:0] == 2'd2) ? 2'b11 : req_arg[1:0];
    unique case (req_kind_e'(req_kind))
      REQ_MUTE: begin
        if (sys_cur[SYS_MUTE] != req_arg[0]) begin
          step_a[SYS_MUTE] = req_arg[0];
          job.sys_a_en     = 1'b1;
          job.sys_a        = step_a;
          job.cdc_en       = 1'b1;
          job.cdc_vol      = 1'b1;
          job.cdc_mask     = CDC_SMUTE;
          job.cdc_val      = req_arg[0] ? CDC_SMUTE : 8'h00;
        end
      end
      REQ_PHANTOM: begin
        if (req_arg[0] && !sys_cur[SYS_PH48]) begin
          step_a[SYS_PH48] = 1'b1;
          job.sys_a_en     = 1'b1;
          job.sys_a        = step_a;
          job.sys_b_en     = 1'b1;
          job.sys_b        = step_a & ~(8'h1 << SYS_PHOFF);
        end else if (!req_arg[0] && sys_cur[SYS_PH48]) begin
          step_a[SYS_PH48] = 1'b0;
          job.sys_a_en     = 1'b1;
          job.sys_a        = step_a;
          job.sys_b_en     = 1'b1;
          job.sys_b        = step_a | (8'h1 << SYS_PHOFF);
        end
      end
      REQ_INMODE: begin
        if (src_ok && (src_code != sys_cur[SYS_SRC_HI:SYS_SRC_LO])) begin
          job.sys_a_en = 1'b1;
          job.sys_b_en = 1'b1;
          if (src_code == 2'b00) begin
            step_a[SYS_SRC_HI:SYS_SRC_LO] = 2'b00;
            job.sys_a = step_a;
            job.sys_b = step_a & ~(8'h1 << SYS_RELAY);
          end else begin
            step_a[SYS_RELAY] = 1'b1;
            job.sys_a = step_a;
            job.sys_b = {step_a[7:6], src_code, step_a[3:0]};
          end
        end
      end
      REQ_RATE: begin
        if (req_arg != '0) begin
          job.cdc_en   = 1'b1;
          job.cdc_vol  = 1'b0;
          job.cdc_mask = CDC_FMT_MASK;
          if (req_arg > ARG_W'(HI_RATE))       job.cdc_val = CDC_FMT_QUAD;
          else if (req_arg > ARG_W'(MID_RATE)) job.cdc_val = CDC_FMT_DUAL;
          else                                 job.cdc_val = 8'h00;
        end
      end
      default: job = '0;
    endcase
  end

endmodule

// File: rtl/afe_codec_shadow.sv
module afe_codec_shadow #(
  parameter int NUM_CODECS = 2,
  parameter int CHIP_W     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHIP_W-1:0] rd_chip,
  input  logic              rd_vol,
  input  logic [7:0]        mask,
  input  logic [7:0]        val,
  output logic [7:0]        wr_data,
  output logic              same,
  input  logic              upd_en,
  input  logic [CHIP_W-1:0] upd_chip,
  input  logic              upd_vol,
  input  logic [7:0]        upd_data
);

  logic [7:0]            fmt_q [NUM_CODECS];
  logic [7:0]            vol_q [NUM_CODECS];
  logic [NUM_CODECS-1:0] hit;
  logic [7:0]            cur;

  for (genvar c = 0; c < NUM_CODECS; c++) begin : g_hit
    assign hit[c] = upd_en && (upd_chip == CHIP_W'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CODECS; c++) begin
        fmt_q[c] <= '0;
        vol_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CODECS; c++) begin
        if (hit[c] && !upd_vol) fmt_q[c] <= upd_data;
        if (hit[c] &&  upd_vol) vol_q[c] <= upd_data;
      end
    end
  end

  always_comb begin
    cur = '0;
    for (int c = 0; c < NUM_CODECS; c++) begin
      if (rd_chip == CHIP_W'(c)) cur = rd_vol ? vol_q[c] : fmt_q[c];
    end
    wr_data = (cur & ~mask) | val;
    same    = (wr_data == cur);
  end

  AST_ONEHOT_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)) // R8
    else $error("AST_ONEHOT_UPD");

endmodule

// File: rtl/afe_seq_ctrl.sv
module afe_seq_ctrl
  import afe_seq_pkg::*;
#(
  parameter int NUM_CODECS = 2,
  parameter int CHIP_W     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  job_t              job_i,
  output logic              req_ready,
  output logic              busy,
  output logic [7:0]        sys_cur,
  output logic              lat_valid,
  output logic [1:0]        lat_sel,
  output logic [7:0]        lat_data,
  input  logic              lat_ack,
  output logic              cdc_valid,
  output logic [CHIP_W-1:0] cdc_chip,
  output logic              cdc_vol,
  output logic [7:0]        cdc_mask,
  output logic [7:0]        cdc_val,
  input  logic [7:0]        cdc_data,
  input  logic              cdc_same,
  input  logic              cdc_ack
);

  localparam logic [CHIP_W-1:0] LAST_CHIP = CHIP_W'(NUM_CODECS - 1);

  typedef enum logic [2:0] {
    ST_INIT_HOLD, ST_INIT_RUN, ST_INIT_MON, ST_INIT_CLK,
    ST_IDLE, ST_SYS_A, ST_SYS_B, ST_CODEC
  } st_e;

  st_e               state_q, state_d;
  job_t              job_q;
  logic              job_en;
  logic [7:0]        sys_q;
  logic              sys_en;
  logic [CHIP_W-1:0] chip_q, chip_d;
  logic              adv;

  always_comb begin
    state_d   = state_q;
    chip_d    = chip_q;
    lat_valid = 1'b0;
    lat_sel   = LAT_SYS;
    lat_data  = '0;
    cdc_valid = 1'b0;
    req_ready = 1'b0;
    adv       = 1'b0;
    unique case (state_q)
      ST_INIT_HOLD: begin
        lat_valid = 1'b1;
        lat_data  = INIT_SYS_HOLD;
        if (lat_ack) state_d = ST_INIT_RUN;
      end
      ST_INIT_RUN: begin
        lat_valid = 1'b1;
        lat_data  = INIT_SYS_RUN;
        if (lat_ack) state_d = ST_INIT_MON;
      end
      ST_INIT_MON: begin
        lat_valid = 1'b1;
        lat_sel   = LAT_MON;
        if (lat_ack) state_d = ST_INIT_CLK;
      end
      ST_INIT_CLK: begin
        lat_valid = 1'b1;
        lat_sel   = LAT_CLK;
        if (lat_ack) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        req_ready = 1'b1;
        chip_d    = '0;
        if (req_valid) begin
          if (job_i.sys_a_en)    state_d = ST_SYS_A;
          else if (job_i.cdc_en) state_d = ST_CODEC;
        end
      end
      ST_SYS_A: begin
        lat_valid = 1'b1;
        lat_data  = job_q.sys_a;
        if (lat_ack) begin
          if (job_q.sys_b_en)     state_d = ST_SYS_B;
          else if (job_q.cdc_en)  state_d = ST_CODEC;
          else                    state_d = ST_IDLE;
        end
      end
      ST_SYS_B: begin
        lat_valid = 1'b1;
        lat_data  = job_q.sys_b;
        if (lat_ack) state_d = job_q.cdc_en ? ST_CODEC : ST_IDLE;
      end
      ST_CODEC: begin
        if (cdc_same) begin
          adv = 1'b1;
        end else begin
          cdc_valid = 1'b1;
          adv       = cdc_ack;
        end
        if (adv) begin
          if (chip_q == LAST_CHIP) state_d = ST_IDLE;
          else                     chip_d  = chip_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign job_en = req_ready && req_valid;
  assign sys_en = lat_valid && lat_ack && (lat_sel == LAT_SYS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT_HOLD;
      chip_q  <= '0;
    end else begin
      state_q <= state_d;
      chip_q  <= chip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      job_q <= '0;
    else if (job_en) job_q <= job_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sys_q <= '0;
    else if (sys_en) sys_q <= lat_data;
  end

  assign busy     = (state_q != ST_IDLE);
  assign sys_cur  = sys_q;
  assign cdc_chip = chip_q;
  assign cdc_vol  = job_q.cdc_vol;
  assign cdc_mask = job_q.cdc_mask;
  assign cdc_val  = job_q.cdc_val;

  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lat_valid && !lat_ack |=> lat_valid && $stable(lat_data) && $stable(lat_sel)) // R11
    else $error("AST_LAT_HOLD");
  AST_CDC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_valid && !cdc_ack |=> cdc_valid && $stable(cdc_data) && $stable(cdc_chip)) // R11
    else $error("AST_CDC_HOLD");
  AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lat_valid && cdc_valid)) // R11
    else $error("AST_ONE_ENGINE");
  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sys_q[SYS_SRC_HI:SYS_SRC_LO] != 2'b10) // R5
    else $error("AST_SRC_LEGAL");
  AST_RELAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_q[SYS_SRC_HI:SYS_SRC_LO] != 2'b00) |-> sys_q[SYS_RELAY]) // R6
    else $error("AST_RELAY_FIRST");
  AST_PH_ON_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_q[SYS_PHOFF]) |-> sys_q[SYS_PH48]) // R3
    else $error("AST_PH_ON_ORDER");
  AST_PH_OFF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_q[SYS_PHOFF]) |-> !sys_q[SYS_PH48]) // R4
    else $error("AST_PH_OFF_ORDER");
  AST_CDC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cdc_valid || lat_valid) |-> busy && !req_ready) // R11
    else $error("AST_CDC_BUSY");

endmodule

// File: rtl/afe_ctrl_seq.sv
module afe_ctrl_seq
  import afe_seq_pkg::*;
#(
  parameter int NUM_CODECS = 2,
  parameter int ARG_W      = 18,
  parameter int HI_RATE    = 108000,
  parameter int MID_RATE   = 54000,
  localparam int CHIP_W    = (NUM_CODECS > 1) ? $clog2(NUM_CODECS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ARG_W-1:0]  req_arg,
  output logic              req_ready,
  output logic              busy,
  output logic              lat_valid,
  output logic [1:0]        lat_sel,
  output logic [7:0]        lat_data,
  input  logic              lat_ack,
  output logic              cdc_valid,
  output logic [CHIP_W-1:0] cdc_chip,
  output logic [4:0]        cdc_addr,
  output logic [7:0]        cdc_data,
  input  logic              cdc_ack
);

  job_t       job;
  logic [7:0] sys_cur;
  logic       cdc_vol;
  logic [7:0] cdc_mask;
  logic [7:0] cdc_val;
  logic       cdc_same;

  afe_req_decode #(
    .ARG_W(ARG_W), .HI_RATE(HI_RATE), .MID_RATE(MID_RATE)
  ) u_decode (
    .req_kind (req_kind),
    .req_arg  (req_arg),
    .sys_cur  (sys_cur),
    .job      (job)
  );

  afe_seq_ctrl #(
    .NUM_CODECS(NUM_CODECS), .CHIP_W(CHIP_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .job_i     (job),
    .req_ready (req_ready),
    .busy      (busy),
    .sys_cur   (sys_cur),
    .lat_valid (lat_valid),
    .lat_sel   (lat_sel),
    .lat_data  (lat_data),
    .lat_ack   (lat_ack),
    .cdc_valid (cdc_valid),
    .cdc_chip  (cdc_chip),
    .cdc_vol   (cdc_vol),
    .cdc_mask  (cdc_mask),
    .cdc_val   (cdc_val),
    .cdc_data  (cdc_data),
    .cdc_same  (cdc_same),
    .cdc_ack   (cdc_ack)
  );

  afe_codec_shadow #(
    .NUM_CODECS(NUM_CODECS), .CHIP_W(CHIP_W)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_chip  (cdc_chip),
    .rd_vol   (cdc_vol),
    .mask     (cdc_mask),
    .val      (cdc_val),
    .wr_data  (cdc_data),
    .same     (cdc_same),
    .upd_en   (cdc_valid && cdc_ack),
    .upd_chip (cdc_chip),
    .upd_vol  (cdc_vol),
    .upd_data (cdc_data)
  );

  assign cdc_addr = cdc_vol ? CDC_REG_VOL : CDC_REG_FMT;

endmodule

// File: tb/afe_ctrl_seq_bench.sv
module afe_ctrl_seq_bench;

  localparam int NC    = 2;
  localparam int ARG_W = 18;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [1:0]       req_kind = '0;
  logic [ARG_W-1:0] req_arg = '0;
  logic             req_ready, busy;
  logic             lat_valid;
  logic [1:0]       lat_sel;
  logic [7:0]       lat_data;
  logic             lat_ack = 1'b0;
  logic             cdc_valid;
  logic [0:0]       cdc_chip;
  logic [4:0]       cdc_addr;
  logic [7:0]       cdc_data;
  logic             cdc_ack = 1'b0;

  afe_ctrl_seq u_afe_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_arg(req_arg), .req_ready(req_ready), .busy(busy),
    .lat_valid(lat_valid), .lat_sel(lat_sel), .lat_data(lat_data), .lat_ack(lat_ack),
    .cdc_valid(cdc_valid), .cdc_chip(cdc_chip), .cdc_addr(cdc_addr),
    .cdc_data(cdc_data), .cdc_ack(cdc_ack)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  // entry packing: {kind(1), sel_or_chip(2), addr(5), data(8)}
  logic [15:0] log_q [16];
  int          log_n = 0;
  logic [15:0] exp_q [16];
  int          exp_n = 0;

  logic [7:0] m_sys;
  logic [7:0] m_fmt [NC];
  logic [7:0] m_vol [NC];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push_exp(input bit k, input logic [1:0] a, input logic [4:0] b,
                          input logic [7:0] d);
    if (exp_n < 16) exp_q[exp_n] = {k, a, b, d};
    exp_n++;
  endtask

  // converter responder and latch responder
  int lat_wait = 0;
  int cdc_wait = 0;
  always @(negedge clk) begin
    lat_ack = 1'b0;
    cdc_ack = 1'b0;
    if (rst_n && lat_valid) begin
      if (lat_wait == 0) begin
        lat_ack = 1'b1;
        if (log_n < 16) log_q[log_n] = {1'b0, lat_sel, 5'd0, lat_data};
        log_n++;
        lat_wait = $urandom % 3;
      end else lat_wait--;
    end
    if (rst_n && cdc_valid) begin
      if (cdc_wait == 0) begin
        cdc_ack = 1'b1;
        if (log_n < 16) log_q[log_n] = {1'b1, 1'b0, cdc_chip, cdc_addr, cdc_data};
        log_n++;
        cdc_wait = $urandom % 3;
      end else cdc_wait--;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  task automatic model_codec(input bit vol, input logic [7:0] mask,
                             input logic [7:0] val);
    for (int c = 0; c < NC; c++) begin
      logic [7:0] cur, nd;
      cur = vol ? m_vol[c] : m_fmt[c];
      nd  = (cur & ~mask) | val;
      if (nd != cur) begin
        push_exp(1'b1, 2'(c), vol ? 5'd3 : 5'd2, nd);
        if (vol) m_vol[c] = nd; else m_fmt[c] = nd;
      end
    end
  endtask

  task automatic model(input logic [1:0] kind, input logic [ARG_W-1:0] arg);
    logic [7:0] s;
    logic [1:0] code;
    case (kind)
      2'd0: if (m_sys[2] != arg[0]) begin
        s = m_sys; s[2] = arg[0]; push_exp(0, 0, 0, s); m_sys = s;
        model_codec(1'b1, 8'h80, arg[0] ? 8'h80 : 8'h00);
      end
      2'd1: begin
        if (arg[0] && !m_sys[1]) begin
          s = m_sys | 8'h02; push_exp(0, 0, 0, s);
          s = s & 8'hF7;     push_exp(0, 0, 0, s); m_sys = s;
        end else if (!arg[0] && m_sys[1]) begin
          s = m_sys & 8'hFD; push_exp(0, 0, 0, s);
          s = s | 8'h08;     push_exp(0, 0, 0, s); m_sys = s;
        end
      end
      2'd2: if (arg[1:0] != 2'd3) begin
        code = (arg[1:0] == 2'd2) ? 2'b11 : arg[1:0];
        if (code != m_sys[5:4]) begin
          if (code == 2'b00) begin
            s = m_sys & 8'hCF; push_exp(0, 0, 0, s);
            s = s & 8'hFE;     push_exp(0, 0, 0, s);
          end else begin
            s = m_sys | 8'h01; push_exp(0, 0, 0, s);
            s[5:4] = code;     push_exp(0, 0, 0, s);
          end
          m_sys = s;
        end
      end
      default: if (arg != 0) begin
        if (arg > 108000)     model_codec(1'b0, 8'h0F, 8'h0A);
        else if (arg > 54000) model_codec(1'b0, 8'h0F, 8'h05);
        else                  model_codec(1'b0, 8'h0F, 8'h00);
      end
    endcase
  endtask

  task automatic compare(input string tag);
    check(log_n == exp_n, {tag, " write count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n && i < 16; i++)
      check(log_q[i] == exp_q[i], {tag, " write entry"}, log_q[i], exp_q[i]);
  endtask

  task automatic do_req(input logic [1:0] kind, input logic [ARG_W-1:0] arg,
                        input string tag);
    exp_n = 0;
    model(kind, arg);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    log_n = 0;
    req_kind  = kind;
    req_arg   = arg;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    check(req_ready == 1'b1, {tag, " R11 ready after busy"}, req_ready, 1);
    compare(tag);
  endtask

  initial begin
    int rates [10];
    void'($urandom(32'd20240611));
    rates = '{0, 32000, 44100, 54000, 54001, 96000, 108000, 108001, 176400, 192000};
    m_sys = 8'h88;
    for (int c = 0; c < NC; c++) begin m_fmt[c] = 0; m_vol[c] = 0; end
    repeat (3) @(negedge clk);
    check(busy == 1'b1 && req_ready == 1'b0, "R1 reset state busy/ready",
          {busy, req_ready}, 2'b10);
    log_n = 0;
    rst_n = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_n = 0;
    push_exp(0, 0, 0, 8'h08);
    push_exp(0, 0, 0, 8'h88);
    push_exp(0, 1, 0, 8'h00);
    push_exp(0, 2, 0, 8'h00);
    compare("R1 init");

    do_req(2'd0, 1, "R8 mute on");
    do_req(2'd0, 1, "R10 mute repeated");
    do_req(2'd0, 0, "R8 unmute");
    do_req(2'd1, 1, "R3 R2 phantom on");
    do_req(2'd1, 1, "R10 phantom on repeated");
    do_req(2'd1, 0, "R4 phantom off");
    do_req(2'd2, 1, "R5 mic");
    do_req(2'd2, 2, "R5 low-cut");
    do_req(2'd2, 2, "R10 low-cut repeated");
    do_req(2'd2, 0, "R6 line");
    do_req(2'd2, 3, "R7 index 3");
    do_req(2'd3, 192000, "R9 rate high");
    do_req(2'd3, 108000, "R9 rate 108000");
    do_req(2'd3, 108001, "R9 rate 108001");
    do_req(2'd3, 54000, "R9 rate 54000");
    do_req(2'd3, 54001, "R9 rate 54001");
    do_req(2'd3, 54001, "R10 rate repeated");
    do_req(2'd3, 0, "R10 rate zero");
    do_req(2'd0, 1, "R8 mute keeps format bits");

    for (int i = 0; i < 120; i++) begin
      logic [1:0] k;
      logic [ARG_W-1:0] a;
      k = 2'($urandom % 4);
      a = (k == 2'd3) ? ARG_W'(rates[$urandom % 10]) : ARG_W'($urandom % 4);
      do_req(k, a, "R11 random mix");
    end

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule